// File: doc/BRIEF.md
# Field-Decoded Counter Register File

This block holds the general registers of a small sixteen-bit processor datapath. Every register is a loadable up/down counter. A register can step by one in a single clock without passing through an ALU or over a bus. Each register has two output paths: one onto the shared internal data bus and one onto the address bus. Because both buses are as wide as the registers, any register can serve as a memory pointer.

Two four-bit register-select fields are taken straight from the instruction word: a source select and a destination select. Three independent one-hot decoders turn them into three sets of lines:

- read enables, which put a register onto the data bus;
- write strobes, which load a register from the data bus;
- address enables, which put a register onto the address bus.

The transfer type decides which field feeds which decoder. In a memory access, one field names the data register and the other names the pointer register. A separate count control steps the destination register, or both selected registers together when the dual flag is set.

Eight registers are implemented behind the sixteen possible select codes. The enable lines are brought out so that the surrounding datapath, or a bench, can check that each bus has at most one driver.

Top module: `fdc_regfile`

## Requirements
- R1: After reset every register reads as 0x0000.
- R2: `rd_en_o` is one-hot on the source index for transfer codes 1 (move) and 3 (store), and all zero otherwise. Bit k of every enable vector stands for register k.
- R3: `wr_en_o` is one-hot on the destination index for transfer codes 1 (move) and 2 (load), and all zero otherwise.
- R4: `ad_en_o` is one-hot on the source index for code 2 (load), on the destination index for code 3 (store), and all zero for codes 0 (idle) and 1 (move).
- R5: A move copies the source register into the destination register at the next clock edge.
- R6: A load writes `data_i` into the destination register at the next clock edge.
- R7: Count code 1 increments and count code 2 decrements the destination register in one clock, wrapping modulo 2^16. Codes 0 and 3 hold the register.
- R8: With `dual_i` set, a count steps the source and destination registers in the same clock. If both fields name the same register, it steps once.
- R9: When a register is written and counted in the same cycle, the written value wins.
- R10: A select value of 8 to 15 asserts no enable for that field, and the register side of the data bus reads 0. A move from such a source loads 0. A write or count aimed at such an index changes no register.
- R11: `dbus_o` equals the register whose read enable is high, and `abus_o` equals the register whose address enable is high. Each bus is 0x0000 when no enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 4 | Source register select field |
| dst_i | input | 4 | Destination register select field |
| op_i | input | 2 | Transfer type: 0 idle, 1 move, 2 load, 3 store |
| cnt_i | input | 2 | Count control: 0 hold, 1 increment, 2 decrement, 3 hold |
| dual_i | input | 1 | Count the source register as well as the destination register |
| data_i | input | 16 | Value on the data bus from outside the block (memory or ALU), used by loads |
| dbus_o | output | 16 | Register contribution to the internal data bus |
| abus_o | output | 16 | Register contribution to the address bus |
| rd_en_o | output | 8 | One-hot data-bus read enables |
| wr_en_o | output | 8 | One-hot write strobes |
| ad_en_o | output | 8 | One-hot address-bus enables |

## Verification
The block is driven first with directed sequences and then with a long pseudo-random stream. The directed part covers:

- loads of distinct values into every register, which tells a correct destination decode from one that aliases two indices;
- moves between registers, which separate the data-bus path from the external input;
- counts at 0x0000 and 0xFFFF, which expose missing wrap-around;
- dual counts with differing and with equal fields, which show whether the source is stepped and whether it is double-stepped.

Collisions of a load with a count on the same register tell which one takes priority. Select values above seven check that out-of-range codes neither alias onto low registers nor leave a stale value on a bus.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
package fdc_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_MOVE  = 2'd1,
    XF_LOAD  = 2'd2,
    XF_STORE = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    CN_HOLD = 2'd0,
    CN_UP   = 2'd1,
    CN_DOWN = 2'd2,
    CN_RSVD = 2'd3
  } cnt_e;
endpackage

// File: rtl/fdc_onehot_dec.sv
`timescale 1ns/1ps
// Select-field decoder: a match only inside 0..NOUT-1, so codes above that give no line.
module fdc_onehot_dec #(
  parameter int SELW = 4,
  parameter int NOUT = 8
) (
  input  logic [SELW-1:0] sel_i,
  input  logic            en_i,
  output logic [NOUT-1:0] hot_o
);
  for (genvar g = 0; g < NOUT; g++) begin : g_line
    assign hot_o[g] = en_i && (sel_i == SELW'(g));
  end
endmodule

// File: rtl/fdc_ctr_reg.sv
`timescale 1ns/1ps
// One register: load has priority over increment, increment over decrement.
module fdc_ctr_reg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q, q_nxt;
  logic          ce;

  assign ce = ld_i | up_i | dn_i;

  always_comb begin
    q_nxt = q_q;
    if (ld_i)      q_nxt = ld_val_i;
    else if (up_i) q_nxt = q_q + DW'(1);
    else if (dn_i) q_nxt = q_q - DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (ce)  q_q <= q_nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fdc_bus_sel.sv
`timescale 1ns/1ps
// Models the register-side tri-state drivers as an AND-OR over one-hot enables.
module fdc_bus_sel #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic [N-1:0]         hot_i,
  input  logic [N-1:0][DW-1:0] val_i,
  output logic [DW-1:0]        bus_o
);
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N; i++) begin
      bus_o = bus_o | (val_i[i] & {DW{hot_i[i]}});
    end
  end
endmodule

// File: rtl/fdc_regfile.sv
`timescale 1ns/1ps
module fdc_regfile #(
  parameter int DW   = 16,
  parameter int SELW = 4,
  parameter int NREG = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SELW-1:0] src_i,
  input  logic [SELW-1:0] dst_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      cnt_i,
  input  logic            dual_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   dbus_o,
  output logic [DW-1:0]   abus_o,
  output logic [NREG-1:0] rd_en_o,
  output logic [NREG-1:0] wr_en_o,
  output logic [NREG-1:0] ad_en_o
);
  import fdc_pkg::*;

  xfer_e xf;
  cnt_e  cn;
  assign xf = xfer_e'(op_i);
  assign cn = cnt_e'(cnt_i);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe_q, rst_pipe_nxt;
  logic       run_n;
  assign rst_pipe_nxt = {rst_pipe_q[0], 1'b1};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= rst_pipe_nxt;
  end
  assign run_n = rst_pipe_q[1];

  // Which field feeds which decoder, by transfer type.
  logic            rd_act, wr_act, ad_act, cnt_act, cnt_up;
  logic [SELW-1:0] ad_sel;
  always_comb begin
    rd_act  = (xf == XF_MOVE) || (xf == XF_STORE);
    wr_act  = (xf == XF_MOVE) || (xf == XF_LOAD);
    ad_act  = (xf == XF_LOAD) || (xf == XF_STORE);
    ad_sel  = (xf == XF_LOAD) ? src_i : dst_i;
    cnt_act = (cn == CN_UP) || (cn == CN_DOWN);
    cnt_up  = (cn == CN_UP);
  end

  logic [NREG-1:0] rd_hot, wr_hot, ad_hot, cd_hot, cs_hot, cnt_hot;

  fdc_onehot_dec #(.SELW(SELW), .NOUT(NREG)) u_dec_rd (
    .sel_i(src_i), .en_i(rd_act), .hot_o(rd_hot));
  fdc_onehot_dec #(.SELW(SELW), .NOUT(NREG)) u_dec_wr (
    .sel_i(dst_i), .en_i(wr_act), .hot_o(wr_hot));
  fdc_onehot_dec #(.SELW(SELW), .NOUT(NREG)) u_dec_ad (
    .sel_i(ad_sel), .en_i(ad_act), .hot_o(ad_hot));
  fdc_onehot_dec #(.SELW(SELW), .NOUT(NREG)) u_dec_cd (
    .sel_i(dst_i), .en_i(cnt_act), .hot_o(cd_hot));
  fdc_onehot_dec #(.SELW(SELW), .NOUT(NREG)) u_dec_cs (
    .sel_i(src_i), .en_i(cnt_act && dual_i), .hot_o(cs_hot));

  assign cnt_hot = cd_hot | cs_hot;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           dbus, abus, wdata;

  fdc_bus_sel #(.N(NREG), .DW(DW)) u_dbus (
    .hot_i(rd_hot), .val_i(regs_q), .bus_o(dbus));
  fdc_bus_sel #(.N(NREG), .DW(DW)) u_abus (
    .hot_i(ad_hot), .val_i(regs_q), .bus_o(abus));

  // A move loads from the register side of the bus; a load takes the outside value.
  assign wdata = (xf == XF_MOVE) ? dbus : data_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    fdc_ctr_reg #(.DW(DW)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (run_n),
      .ld_i     (wr_hot[g]),
      .ld_val_i (wdata),
      .up_i     (cnt_hot[g] && cnt_up),
      .dn_i     (cnt_hot[g] && !cnt_up),
      .q_o      (regs_q[g])
    );
  end

  assign dbus_o  = dbus;
  assign abus_o  = abus;
  assign rd_en_o = rd_hot;
  assign wr_en_o = wr_hot;
  assign ad_en_o = ad_hot;
endmodule

// File: rtl/fdc_regfile_chk.sv
`timescale 1ns/1ps
module fdc_regfile_chk #(
  parameter int DW   = 16,
  parameter int SELW = 4,
  parameter int NREG = 8
) (
  input logic                    clk_i,
  input logic                    run_n,
  input logic [SELW-1:0]         src_i,
  input logic [SELW-1:0]         dst_i,
  input logic [1:0]              op_i,
  input logic [1:0]              cnt_i,
  input logic                    dual_i,
  input logic [DW-1:0]           data_i,
  input logic [NREG-1:0]         rd_en_o,
  input logic [NREG-1:0]         wr_en_o,
  input logic [NREG-1:0]         ad_en_o,
  input logic [NREG-1:0][DW-1:0] regs_q
);
  localparam int IW = $clog2(NREG);

  logic src_ok, dst_ok;
  assign src_ok = (src_i < SELW'(NREG));
  assign dst_ok = (dst_i < SELW'(NREG));

  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!run_n)
    $onehot0(rd_en_o)); // R2
  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!run_n)
    $onehot0(wr_en_o)); // R3
  AST_AD_ONEHOT: assert property (@(posedge clk_i) disable iff (!run_n)
    $onehot0(ad_en_o)); // R4
  AST_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!run_n)
    (!src_ok && !dst_ok) |-> ($countones({rd_en_o, wr_en_o, ad_en_o}) == 0)); // R10
  AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (!run_n)
    (op_i == 2'd2 && dst_ok && cnt_i == 2'd0)
      |=> regs_q[$past(dst_i[IW-1:0])] == $past(data_i)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!run_n)
    (op_i == 2'd2 && dst_ok && cnt_i != 2'd0)
      |=> regs_q[$past(dst_i[IW-1:0])] == $past(data_i)); // R9
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!run_n)
    (op_i == 2'd0 && cnt_i == 2'd1 && dst_ok)
      |=> regs_q[$past(dst_i[IW-1:0])] == DW'($past(regs_q[dst_i[IW-1:0]]) + DW'(1))); // R7
  AST_DUAL_SRC: assert property (@(posedge clk_i) disable iff (!run_n)
    (op_i == 2'd0 && cnt_i == 2'd2 && dual_i && src_ok && dst_ok && src_i != dst_i)
      |=> regs_q[$past(src_i[IW-1:0])] == DW'($past(regs_q[src_i[IW-1:0]]) - DW'(1))); // R8
endmodule

bind fdc_regfile fdc_regfile_chk #(.DW(DW), .SELW(SELW), .NREG(NREG)) u_chk (
  .clk_i   (clk_i),
  .run_n   (run_n),
  .src_i   (src_i),
  .dst_i   (dst_i),
  .op_i    (op_i),
  .cnt_i   (cnt_i),
  .dual_i  (dual_i),
  .data_i  (data_i),
  .rd_en_o (rd_en_o),
  .wr_en_o (wr_en_o),
  .ad_en_o (ad_en_o),
  .regs_q  (regs_q)
);

// File: tb/fdc_regfile_tb_top.sv
`timescale 1ns/1ps
module fdc_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src_i = '0, dst_i = '0;
  logic [1:0]  op_i = '0, cnt_i = '0;
  logic        dual_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] dbus_o, abus_o;
  logic [7:0]  rd_en_o, wr_en_o, ad_en_o;

  always #2.5 clk_i = ~clk_i;

  fdc_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .dst_i(dst_i),
    .op_i(op_i), .cnt_i(cnt_i), .dual_i(dual_i), .data_i(data_i),
    .dbus_o(dbus_o), .abus_o(abus_o),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .ad_en_o(ad_en_o)
  );

  int errors = 0;
  int checks = 0;
  int model[8];
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare, then advance the model at the rising edge.
  task automatic cyc(input int op, input int s, input int d, input int cn,
                     input bit du, input int dat, input string tag);
    int erd, ewr, ead, edb, eab, delta, wv;
    int nm[8];
    src_i = 4'(s); dst_i = 4'(d); op_i = 2'(op); cnt_i = 2'(cn);
    dual_i = du; data_i = 16'(dat);
    #1;
    erd = 0; ewr = 0; ead = 0; edb = 0; eab = 0;
    if ((op == 1 || op == 3) && s < 8) begin erd = 1 << s; edb = model[s]; end
    if ((op == 1 || op == 2) && d < 8) ewr = 1 << d;
    if (op == 2 && s < 8) begin ead = 1 << s; eab = model[s]; end
    if (op == 3 && d < 8) begin ead = 1 << d; eab = model[d]; end
    chk({tag, " rd_en (R2)"}, int'(rd_en_o), erd);
    chk({tag, " wr_en (R3)"}, int'(wr_en_o), ewr);
    chk({tag, " ad_en (R4)"}, int'(ad_en_o), ead);
    chk({tag, " dbus (R11)"}, int'(dbus_o), edb);
    chk({tag, " abus (R11)"}, int'(abus_o), eab);
    chk({tag, " single driver"}, int'($countones(rd_en_o) <= 1 && $countones(ad_en_o) <= 1), 1);
    nm = model;
    delta = (cn == 1) ? 1 : (cn == 2) ? -1 : 0;
    wv = (op == 1) ? edb : (dat & 16'hFFFF);
    if (delta != 0) begin
      if (d < 8) nm[d] = (model[d] + delta) & 16'hFFFF;
      if (du && s < 8 && s != d) nm[s] = (model[s] + delta) & 16'hFFFF;
    end
    if (ewr != 0) nm[d] = wv;
    @(posedge clk_i);
    model = nm;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    foreach (model[k]) model[k] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1: every register reads zero after reset
    for (int k = 0; k < 8; k++) cyc(3, k, 15, 0, 0, 0, "R1 reset value");

    // R6: distinct values into each register
    for (int k = 0; k < 8; k++) cyc(2, 7 - k, k, 0, 0, 16'h1111 * k + 5, "R6 load");
    // R5: moves, then read the destinations back
    cyc(1, 3, 6, 0, 0, 16'hDEAD, "R5 move 3->6");
    cyc(1, 0, 7, 0, 0, 16'hBEEF, "R5 move 0->7");
    cyc(3, 6, 7, 0, 0, 0, "R5 readback");

    // R7: wrap at both ends
    cyc(2, 1, 0, 0, 0, 16'hFFFF, "R7 preload max");
    cyc(0, 0, 0, 1, 0, 0, "R7 increment wrap");
    cyc(3, 0, 1, 0, 0, 0, "R7 check zero");
    cyc(2, 1, 1, 0, 0, 0, "R7 preload zero");
    cyc(0, 2, 1, 2, 0, 0, "R7 decrement wrap");
    cyc(0, 2, 1, 3, 0, 0, "R7 reserved code holds");
    cyc(3, 1, 2, 0, 0, 0, "R7 check max");

    // R8: dual counts
    cyc(0, 2, 5, 1, 1, 0, "R8 dual increment");
    cyc(0, 4, 3, 2, 1, 0, "R8 dual decrement");
    cyc(0, 6, 6, 1, 1, 0, "R8 same register once");
    cyc(3, 6, 2, 0, 0, 0, "R8 readback");

    // R9: load beats count on the same register
    cyc(2, 0, 4, 1, 0, 16'h1234, "R9 load with increment");
    cyc(1, 1, 4, 2, 1, 0, "R9 move with dual decrement");
    cyc(3, 4, 1, 0, 0, 0, "R9 readback");

    // R10: out-of-range indices
    cyc(2, 9, 12, 1, 1, 16'h5555, "R10 load and count high dst");
    cyc(3, 13, 14, 0, 0, 0, "R10 store high fields");
    cyc(1, 10, 3, 0, 0, 16'hAAAA, "R10 move from high src loads zero");
    cyc(3, 3, 11, 0, 0, 0, "R10 readback");

    // Pseudo-random stream covering R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 together
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
      cyc((lf >> 2) & 3, (lf >> 4) & 15, (lf >> 8) & 15, (lf >> 12) & 3,
          (lf >> 14) & 1, (lf >> 16) & 16'hFFFF, "R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule